// File: doc/BRIEF.md
# Timer Channel Set/Clear Control Window

This block is the register front end for a bank of timer channels. Each channel owns a private 64-byte window. The channel number comes from the address bits above bit 5, and the low six bits select a register inside the window.

Four word offsets carry the channel's count, reload and two match values:

- Writes to them leave as one-hot strobes for the timer datapath.
- Reads of them return values that the datapath presents on a flat input bus.

Two further offsets manage the channel's 4-bit control field:

- One offset reads the field and sets bits in it.
- The other offset clears bits in it and can also drop the channel's interrupt status flag.

The status flag is raised by strobes from the datapath. It is packed into the control read word at bit 16.

The control field bits are: bit 0 enable, bit 1 clock select, bit 2 overflow interrupt enable, bit 3 pulse output enable. When one set access turns on the enable together with a configuration bit that was off, the configuration bit takes effect one cycle before the enable. When one clear access turns off the enable together with a configuration bit that was on, the enable drops one cycle before the configuration bit. This ordering ensures the counter never runs with a half-updated configuration.

Top module: `tmr_setclr_win`

## Requirements
- R1: The channel index is req_addr[ADDR_W-1:6] and the in-window offset is req_addr[5:0]. A write at offset 0x00, 0x04, 0x08 or 0x0C of channel c raises wr_stb bit c*4+0, +1, +2 or +3 respectively (count, reload, first match, second match). The strobe is raised in the same cycle as the request, with wr_data equal to req_wdata.
- R2: An access whose channel index is NUM_CH or more raises no strobe and changes no control or status bit, and a read of it returns zero.
- R3: A read returns rd_valid high with rd_data in the cycle after the request. A read at offset 0x10 returns the control field in bits [3:0] and the status flag in bit 16, with all other bits zero.
- R4: A read at offset 0x00/0x04/0x08/0x0C of channel c returns dp_rdata word c*4+0/1/2/3.
- R5: A write at offset 0x10 sets the control bits whose written bits [3:0] are one. All other control bits and all written bits above bit 3 have no effect. The control field is visible on ctrl_out[c*4+:4].
- R6: If a set write requests enable (bit 0) while the channel is disabled, and also turns on a configuration bit (bits 3:1) that was off, the configuration bits appear on the cycle after the write and the enable one cycle later. Otherwise a requested enable appears on the cycle after the write.
- R7: A write at offset 0x14 clears the control bits whose written bits [3:0] are one. If it clears a set enable and also clears a set configuration bit, the enable drops on the cycle after the write and the configuration bits one cycle later. Otherwise all requested clears take effect together.
- R8: A write at offset 0x14 with bit 16 set clears the channel's status flag. A write at offset 0x10 never sets the status flag, whatever bit 16 holds.
- R9: A pulse on stat_set[c] sets status flag c on the next cycle. If it coincides with a clear of that flag, the flag stays set.
- R10: Writes to any other in-window offset raise no strobe and change no state, and reads of them, including offset 0x14, return zero.
- R11: Reset clears every control field, every status flag and the read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | DW | Read data, zero when rd_valid is low |
| wr_stb | output | NUM_CH*4 | One-hot datapath register write strobes |
| wr_data | output | DW | Data accompanying wr_stb |
| dp_rdata | input | NUM_CH*4*DW | Datapath register values, word c*4+r |
| stat_set | input | NUM_CH | Status flag set pulses from the datapath |
| ctrl_out | output | NUM_CH*4 | Control fields, channel c at bits c*4+:4 |
| irq_status | output | NUM_CH | Interrupt status flags |

## Verification
The assertions assume that req_valid, req_write and stat_set are held low during reset, so that the cycles the properties look back over are defined. They also assume that at most one access arrives per cycle, which the single request port enforces. The bench drives every request for exactly one cycle and leaves an idle cycle between accesses. As a result, a deferred enable or deferred configuration clear always completes before the next access to that channel. Reads of datapath registers use a fixed pattern on dp_rdata that encodes channel and register, so a wrong word selection is visible in the returned value.

// File: rtl/tmr_win_pkg.sv
package tmr_win_pkg;
   localparam int CTRL_W      = 4;
   localparam int REGS_PER_CH = 4;
   localparam int WIN_BITS    = 6;
   localparam int STS_POS     = 16;

   localparam int CB_EN    = 0;
   localparam int CB_CLK   = 1;
   localparam int CB_OVF   = 2;
   localparam int CB_PULSE = 3;

   localparam logic [WIN_BITS-1:0] OFS_CTRL_SET = 6'h10;
   localparam logic [WIN_BITS-1:0] OFS_CTRL_CLR = 6'h14;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_DATA,
      ACC_SET,
      ACC_CLR
   } acc_kind_e;
endpackage

// File: rtl/tmr_win_decode.sv
module tmr_win_decode
   import tmr_win_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [1:0]        reg_sel,
   output logic [NUM_CH-1:0] ch_hit
);
   localparam int IDX_W = ADDR_W - WIN_BITS;

   logic [IDX_W-1:0]    idx;
   logic [WIN_BITS-1:0] ofs;
   logic                in_range;

   assign idx      = addr[ADDR_W-1:WIN_BITS];
   assign ofs      = addr[WIN_BITS-1:0];
   assign in_range = |ch_hit;
   assign reg_sel  = ofs[3:2];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
      assign ch_hit[c] = (idx == IDX_W'(c));
   end

   always_comb begin
      kind = ACC_NONE;
      if (in_range) begin
         if (ofs[5:4] == 2'b00 && ofs[1:0] == 2'b00) kind = ACC_DATA;
         else if (ofs == OFS_CTRL_SET)               kind = ACC_SET;
         else if (ofs == OFS_CTRL_CLR)               kind = ACC_CLR;
      end
   end
endmodule

// File: rtl/tmr_win_chan.sv
module tmr_win_chan
   import tmr_win_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic [CTRL_W-1:0] wmask,
   input  logic              sts_clr,
   input  logic              stat_set,
   output logic [CTRL_W-1:0] ctrl,
   output logic              sts
);
   logic [CTRL_W-1:0] ctrl_q, ctrl_n;
   logic              en_pend_q, en_pend_n;
   logic [CTRL_W-2:0] cfg_pend_q, cfg_pend_n;
   logic              sts_q, sts_n;
   logic [CTRL_W-2:0] new_cfg, drop_cfg;

   assign new_cfg  = wmask[CTRL_W-1:1] & ~ctrl_q[CTRL_W-1:1];
   assign drop_cfg = wmask[CTRL_W-1:1] &  ctrl_q[CTRL_W-1:1];

   always_comb begin
      ctrl_n     = ctrl_q;
      en_pend_n  = 1'b0;
      cfg_pend_n = '0;
      // finish a split update left by the previous access
      if (en_pend_q) ctrl_n[CB_EN] = 1'b1;
      ctrl_n[CTRL_W-1:1] = ctrl_n[CTRL_W-1:1] & ~cfg_pend_q;

      if (set_wr) begin
         ctrl_n[CTRL_W-1:1] = ctrl_n[CTRL_W-1:1] | wmask[CTRL_W-1:1];
         if (wmask[CB_EN]) begin
            if (!ctrl_q[CB_EN] && (new_cfg != '0)) en_pend_n = 1'b1;
            else                                   ctrl_n[CB_EN] = 1'b1;
         end
      end else if (clr_wr) begin
         if (wmask[CB_EN] && ctrl_q[CB_EN]) begin
            ctrl_n[CB_EN] = 1'b0;
            cfg_pend_n    = drop_cfg;
         end else begin
            ctrl_n[CB_EN]      = ctrl_n[CB_EN] & ~wmask[CB_EN];
            ctrl_n[CTRL_W-1:1] = ctrl_n[CTRL_W-1:1] & ~wmask[CTRL_W-1:1];
         end
      end

      if (stat_set)              sts_n = 1'b1;
      else if (clr_wr && sts_clr) sts_n = 1'b0;
      else                       sts_n = sts_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         en_pend_q  <= 1'b0;
         cfg_pend_q <= '0;
         sts_q      <= 1'b0;
      end else begin
         ctrl_q     <= ctrl_n;
         en_pend_q  <= en_pend_n;
         cfg_pend_q <= cfg_pend_n;
         sts_q      <= sts_n;
      end
   end

   assign ctrl = ctrl_q;
   assign sts  = sts_q;
endmodule

// File: rtl/tmr_win_rdmux.sv
module tmr_win_rdmux
   import tmr_win_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DW     = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_req,
   input  acc_kind_e                      kind,
   input  logic [1:0]                     reg_sel,
   input  logic [NUM_CH-1:0]              ch_hit,
   input  logic [NUM_CH*REGS_PER_CH*DW-1:0] dp_rdata,
   input  logic [NUM_CH*CTRL_W-1:0]       ctrl_all,
   input  logic [NUM_CH-1:0]              sts_all,
   output logic                           rd_valid,
   output logic [DW-1:0]                  rd_data
);
   logic [DW-1:0] val;

   always_comb begin
      val = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_hit[c]) begin
            if (kind == ACC_DATA) begin
               val = dp_rdata[(c*REGS_PER_CH + int'(reg_sel))*DW +: DW];
            end else if (kind == ACC_SET) begin
               val[CTRL_W-1:0] = ctrl_all[c*CTRL_W +: CTRL_W];
               val[STS_POS]    = sts_all[c];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         rd_data  <= rd_req ? val : '0;
      end
   end
endmodule

// File: rtl/tmr_setclr_win.sv
module tmr_setclr_win
   import tmr_win_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DW     = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic                             req_write,
   input  logic [ADDR_W-1:0]                req_addr,
   input  logic [DW-1:0]                    req_wdata,
   output logic                             rd_valid,
   output logic [DW-1:0]                    rd_data,
   output logic [NUM_CH*REGS_PER_CH-1:0]    wr_stb,
   output logic [DW-1:0]                    wr_data,
   input  logic [NUM_CH*REGS_PER_CH*DW-1:0] dp_rdata,
   input  logic [NUM_CH-1:0]                stat_set,
   output logic [NUM_CH*CTRL_W-1:0]         ctrl_out,
   output logic [NUM_CH-1:0]                irq_status
);
   if (ADDR_W <= WIN_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed the window width");
   end
   if (NUM_CH < 1 || NUM_CH > (1 << (ADDR_W - WIN_BITS))) begin : g_bad_ch
      $error("NUM_CH does not fit the channel index field");
   end
   if (DW <= STS_POS) begin : g_bad_dw
      $error("DW too narrow for the status bit");
   end

   acc_kind_e         kind;
   logic [1:0]        reg_sel;
   logic [NUM_CH-1:0] ch_hit;
   logic              wr_go;

   tmr_win_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .addr    (req_addr),
      .kind    (kind),
      .reg_sel (reg_sel),
      .ch_hit  (ch_hit)
   );

   assign wr_go   = req_valid && req_write;
   assign wr_data = req_wdata;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar r = 0; r < REGS_PER_CH; r++) begin : g_stb
         assign wr_stb[c*REGS_PER_CH + r] =
            wr_go && ch_hit[c] && (kind == ACC_DATA) && (reg_sel == 2'(r));
      end

      tmr_win_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_wr   (wr_go && ch_hit[c] && (kind == ACC_SET)),
         .clr_wr   (wr_go && ch_hit[c] && (kind == ACC_CLR)),
         .wmask    (req_wdata[CTRL_W-1:0]),
         .sts_clr  (req_wdata[STS_POS]),
         .stat_set (stat_set[c]),
         .ctrl     (ctrl_out[c*CTRL_W +: CTRL_W]),
         .sts      (irq_status[c])
      );
   end

   tmr_win_rdmux #(.NUM_CH(NUM_CH), .DW(DW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (req_valid && !req_write),
      .kind     (kind),
      .reg_sel  (reg_sel),
      .ch_hit   (ch_hit),
      .dp_rdata (dp_rdata),
      .ctrl_all (ctrl_out),
      .sts_all  (irq_status),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/tmr_setclr_win_chk.sv
module tmr_setclr_win_chk
   import tmr_win_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DW     = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_valid,
   input logic                          req_write,
   input logic [ADDR_W-1:0]             req_addr,
   input logic                          rd_valid,
   input logic [DW-1:0]                 rd_data,
   input logic [NUM_CH*REGS_PER_CH-1:0] wr_stb,
   input logic [NUM_CH-1:0]             stat_set,
   input logic [NUM_CH*CTRL_W-1:0]      ctrl_out,
   input logic [NUM_CH-1:0]             irq_status
);
   localparam int IDX_W = ADDR_W - WIN_BITS;

   logic out_of_range;
   assign out_of_range = int'(req_addr[ADDR_W-1:WIN_BITS]) >= NUM_CH;

   // R1: at most one datapath register strobe per cycle
   a_r1_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));

   // R2: out-of-range channel never strobes
   a_r2_no_stb_far: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && out_of_range) |-> (wr_stb == '0));

   // R3: read data follows a read request by one cycle
   a_r3_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));

   // R11: idle read output is zero
   a_r11_rd_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R9: a status flag rises only from a datapath strobe
      a_r9_sts_source: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_status[c]) |-> $past(stat_set[c]));

      // R5: configuration bits rise only right after a write
      a_r5_cfg_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(ctrl_out[c*CTRL_W+1 +: CTRL_W-1] &
                     ~$past(ctrl_out[c*CTRL_W+1 +: CTRL_W-1])) != 0)
         |-> $past(req_valid && req_write));

      // R6: enable rises within two cycles of a write
      a_r6_en_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ctrl_out[c*CTRL_W + CB_EN])
         |-> ($past(req_valid && req_write) || $past(req_valid && req_write, 2)));
   end
endmodule

bind tmr_setclr_win tmr_setclr_win_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W),
   .DW     (DW)
) u_chk (.*);

// File: tb/tb_tmr_setclr_win.sv
module tb_tmr_setclr_win;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 8;
   localparam int ADDR_W = 10;
   localparam int DW     = 32;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     req_valid = 1'b0;
   logic                     req_write = 1'b0;
   logic [ADDR_W-1:0]        req_addr = '0;
   logic [DW-1:0]            req_wdata = '0;
   logic                     rd_valid;
   logic [DW-1:0]            rd_data;
   logic [NUM_CH*4-1:0]      wr_stb;
   logic [DW-1:0]            wr_data;
   logic [NUM_CH*4*DW-1:0]   dp_rdata;
   logic [NUM_CH-1:0]        stat_set = '0;
   logic [NUM_CH*4-1:0]      ctrl_out;
   logic [NUM_CH-1:0]        irq_status;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [NUM_CH*4-1:0] cap_stb;
   logic [DW-1:0]       cap_wd;
   logic [NUM_CH*4-1:0] snap_ctrl;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_setclr_win #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW)) dut (.*);

   initial begin
      for (int c = 0; c < NUM_CH; c++)
         for (int r = 0; r < 4; r++)
            dp_rdata[(c*4+r)*DW +: DW] = 32'hD000_0000 | (c << 8) | r;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] ad(input int ch, input int ofs);
      return ADDR_W'(ch*64 + ofs);
   endfunction

   function automatic logic [31:0] ctl(input int ch);
      return 32'(ctrl_out[ch*4 +: 4]);
   endfunction

   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      #1;
      cap_stb = wr_stb;
      cap_wd  = wr_data;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errs++;
            $display("FAIL R3 unexpected read data actual=%h expected=none", rd_data);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ctrl reset", ctrl_out, 0);
      chk("R11 status reset", 32'(irq_status), 0);
      chk("R11 rd_valid reset", 32'(rd_valid), 0);

      bus_wr(ad(5, 8), 32'h0000_ABCD);
      chk("R1 strobe ch5 match1", cap_stb, 32'h1 << 22);
      chk("R1 wr_data", cap_wd, 32'h0000_ABCD);
      bus_wr(ad(0, 0), 32'h1);
      chk("R1 strobe ch0 count", cap_stb, 32'h1);
      bus_wr(ad(7, 12), 32'h5);
      chk("R1 strobe ch7 match2", cap_stb, 32'h8000_0000);
      chk("R1 data writes leave ctrl", ctrl_out, 0);

      bus_rd(ad(6, 4), 32'hD000_0601, "R4 ch6 reload");
      bus_rd(ad(0, 12), 32'hD000_0003, "R4 ch0 match2");

      bus_wr(ad(3, 16), 32'h0001_FFF6);
      chk("R5 set ch3", ctl(3), 32'h6);
      chk("R5 other channels", ctrl_out & ~(32'hF << 12), 0);
      chk("R8 set never raises status", 32'(irq_status), 0);
      bus_rd(ad(3, 16), 32'h6, "R3 ctrl read ch3");

      @(negedge clk); stat_set = 8'h08;
      @(negedge clk); stat_set = 8'h00;
      chk("R9 status set", 32'(irq_status), 32'h08);
      bus_rd(ad(3, 16), 32'h0001_0006, "R3 ctrl+status read ch3");
      bus_wr(ad(3, 20), 32'h0001_0000);
      chk("R8 status cleared", 32'(irq_status), 0);
      chk("R8 ctrl kept", ctl(3), 32'h6);

      @(negedge clk);
      stat_set = 8'h08;
      req_valid = 1'b1; req_write = 1'b1; req_addr = ad(3, 20); req_wdata = 32'h0001_0000;
      @(negedge clk);
      stat_set = 8'h00; req_valid = 1'b0; req_write = 1'b0;
      chk("R9 set beats clear", 32'(irq_status), 32'h08);
      bus_wr(ad(3, 20), 32'h0001_0000);
      chk("R8 clear after collision", 32'(irq_status), 0);

      bus_wr(ad(2, 16), 32'hF);
      chk("R6 config first", ctl(2), 32'hE);
      @(negedge clk);
      chk("R6 enable second", ctl(2), 32'hF);
      bus_wr(ad(2, 20), 32'h1);
      chk("R7 enable-only clear", ctl(2), 32'hE);
      bus_wr(ad(2, 16), 32'h1);
      chk("R6 enable-only set immediate", ctl(2), 32'hF);
      bus_wr(ad(2, 20), 32'hF);
      chk("R7 enable drops first", ctl(2), 32'hE);
      @(negedge clk);
      chk("R7 config drops second", ctl(2), 32'h0);
      bus_wr(ad(4, 16), 32'h6);
      bus_wr(ad(4, 20), 32'h2);
      chk("R7 config-only clear", ctl(4), 32'h4);

      snap_ctrl = ctrl_out;
      bus_wr(10'h200, 32'h0001_000F);
      chk("R2 no strobe idx8", cap_stb, 0);
      bus_wr(10'h3C4, 32'h1);
      chk("R2 no strobe idx15", cap_stb, 0);
      @(negedge clk);
      chk("R2 ctrl unchanged", ctrl_out, snap_ctrl);
      bus_rd(10'h210, 32'h0, "R2 read idx8 ctrl");
      bus_rd(10'h204, 32'h0, "R2 read idx8 reload");

      bus_wr(ad(1, 24), 32'hF);
      chk("R10 no strobe 0x18", cap_stb, 0);
      bus_wr(ad(1, 5), 32'hF);
      chk("R10 no strobe 0x05", cap_stb, 0);
      @(negedge clk);
      chk("R10 ctrl unchanged", ctrl_out, snap_ctrl);
      bus_rd(ad(1, 20), 32'h0, "R10 read clear offset");
      bus_rd(ad(1, 32), 32'h0, "R10 read 0x20");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errs++;
         $display("FAIL R3 missing reads actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule